// File: doc/BRIEF.md
# Byte Stack Push Unit

This unit carries out one stack push of a single byte. A command names a source register (index 0 to 7), picks one of two stack pointers, and says whether that pointer counts up or down. Each pointer has its own bank value. The unit steps the chosen pointer first, with wrap-around. It then writes the byte to the memory location formed from that pointer's bank and the stepped pointer value.

Sources 0 to 3 come from the register file read port, and only their low byte is used. Sources 4 to 7 do not read the register file. For those, the unit runs an input cycle on the I/O bus to the peripheral named by the peripheral address input, and pushes the byte that the I/O read returns.

The pointers and banks live outside the unit. At the end of a push, the unit hands back the new pointer value and a write strobe, and pulses `done` for one cycle.

Top module: `byte_stack_push`

## Requirements
- R1: For sources 0 to 3, the byte written to memory is bits 7:0 of `rf_data`, read while `rf_addr` equals the command's source index. Bits above 7 have no effect on the write.
- R2: `cmd_sel`=0 uses `ptr0`/`bank0` and `cmd_sel`=1 uses `ptr1`/`bank1`. The write address is `{bank, stepped pointer}`, with the bank in the upper BW bits.
- R3: `cmd_dec`=0 adds one to the pointer and `cmd_dec`=1 subtracts one. At completion, `ptr_we` is high, `ptr_sel` names the pointer used, and `ptr_new` carries the stepped value.
- R4: The memory write uses the pointer value after the step, never the value before it.
- R5: Pointer steps wrap modulo 2^PW: all-ones plus one gives zero, and zero minus one gives all-ones.
- R6: A source index with bit 2 set (4 to 7) raises `io_req` with `io_addr` equal to the `pa` value captured at command time, and the pushed byte is `io_rdata`. Sources 0 to 3 never raise `io_req`.
- R7: On an I/O push, `mem_req` does not rise before `io_ack` has been seen.
- R8: `mem_req`, `mem_addr` and `mem_wdata` hold steady until `mem_ack`. `done` and `ptr_we` are high for exactly the one clock after the cycle in which `mem_ack` was accepted.
- R9: After reset, `busy`, `mem_req`, `io_req`, `done` and `ptr_we` are all low.
- R10: `cmd_valid` is accepted only while `busy` is low. A command presented while a push is in progress neither changes that push nor starts another one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Start a push (taken when not busy) |
| cmd_reg | input | 3 | Source register index |
| cmd_sel | input | 1 | Pointer choice: 0 first, 1 second |
| cmd_dec | input | 1 | 1 decrements, 0 increments |
| busy | output | 1 | Push in progress |
| rf_addr | output | 3 | Register file read index |
| rf_data | input | DW | Register file read data |
| ptr0 | input | PW | First stack pointer |
| ptr1 | input | PW | Second stack pointer |
| bank0 | input | BW | Bank for first pointer |
| bank1 | input | BW | Bank for second pointer |
| pa | input | PAW | Peripheral address |
| io_req | output | 1 | I/O input cycle request |
| io_addr | output | PAW | Peripheral addressed |
| io_ack | input | 1 | I/O data valid |
| io_rdata | input | 8 | I/O read byte |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | BW+PW | Write address |
| mem_wdata | output | 8 | Byte written |
| mem_ack | input | 1 | Write accepted |
| ptr_we | output | 1 | Pointer write-back strobe |
| ptr_sel | output | 1 | Pointer being written back |
| ptr_new | output | PW | Stepped pointer value |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to bring about is a second command arriving while a push is stalled on a slow memory or I/O acknowledge. The design must ignore it without corrupting the push already under way. The bench sweeps every source index, both pointers, both directions and the pointer values at the wrap points, and it varies the acknowledge delays across the sweep. On every push that stalls, it presents a conflicting command during the stall. It then checks both the original push's address and data and that no extra push follows.

// File: rtl/byte_stack_push.sv
module byte_stack_push #(
  parameter int DW  = 16,
  parameter int PW  = 8,
  parameter int BW  = 4,
  parameter int PAW = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_reg,
  input  logic             cmd_sel,
  input  logic             cmd_dec,
  output logic             busy,
  output logic [2:0]       rf_addr,
  input  logic [DW-1:0]    rf_data,
  input  logic [PW-1:0]    ptr0,
  input  logic [PW-1:0]    ptr1,
  input  logic [BW-1:0]    bank0,
  input  logic [BW-1:0]    bank1,
  input  logic [PAW-1:0]   pa,
  output logic             io_req,
  output logic [PAW-1:0]   io_addr,
  input  logic             io_ack,
  input  logic [7:0]       io_rdata,
  output logic             mem_req,
  output logic [BW+PW-1:0] mem_addr,
  output logic [7:0]       mem_wdata,
  input  logic             mem_ack,
  output logic             ptr_we,
  output logic             ptr_sel,
  output logic [PW-1:0]    ptr_new,
  output logic             done
);
  localparam int AW = BW + PW;

  typedef enum logic [1:0] {S_IDLE, S_IO, S_MEM, S_DONE} state_t;

  state_t         st;
  logic           sel_q;
  logic           from_io_q;
  logic [PW-1:0]  ptr_q;
  logic [BW-1:0]  bank_q;
  logic [PAW-1:0] pa_q;
  logic [7:0]     byte_q;

  logic           accept;
  logic [PW-1:0]  cur_ptr;
  logic [PW-1:0]  step_ptr;

  assign accept   = cmd_valid && (st == S_IDLE);
  assign cur_ptr  = cmd_sel ? ptr1 : ptr0;
  assign step_ptr = cmd_dec ? cur_ptr - 1'b1 : cur_ptr + 1'b1;
  assign rf_addr  = cmd_reg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      sel_q     <= 1'b0;
      from_io_q <= 1'b0;
      ptr_q     <= '0;
      bank_q    <= '0;
      pa_q      <= '0;
      byte_q    <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          sel_q     <= cmd_sel;
          from_io_q <= cmd_reg[2];
          ptr_q     <= step_ptr;
          bank_q    <= cmd_sel ? bank1 : bank0;
          pa_q      <= pa;
          byte_q    <= rf_data[7:0];
          st        <= cmd_reg[2] ? S_IO : S_MEM;
        end
        S_IO: if (io_ack) begin
          byte_q <= io_rdata;
          st     <= S_MEM;
        end
        S_MEM:  if (mem_ack) st <= S_DONE;
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy      = (st != S_IDLE);
  assign io_req    = (st == S_IO);
  assign io_addr   = pa_q;
  assign mem_req   = (st == S_MEM);
  assign mem_addr  = AW'({bank_q, ptr_q});
  assign mem_wdata = byte_q;
  assign done      = (st == S_DONE);
  assign ptr_we    = done;
  assign ptr_sel   = sel_q;
  assign ptr_new   = ptr_q;

  p_rf_known_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !cmd_reg[2]) |-> !$isunknown(rf_data));

  p_io_only_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    io_req |-> from_io_q);

  p_io_addr_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (io_req && !io_ack) |=> (io_req && $stable(io_addr)));

  p_mem_after_io_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_req) && from_io_q) |-> $past(io_req && io_ack));

  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)));

  p_done_after_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_req && mem_ack));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_no_start_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && cmd_valid && !mem_ack) |=> (mem_req && $stable(mem_addr)));
endmodule

// File: tb/sim_byte_stack_push.sv
module sim_byte_stack_push;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16, PW = 8, BW = 4, PAW = 5;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_sel = 0, cmd_dec = 0;
  logic [2:0] cmd_reg = 0;
  logic busy;
  logic [2:0] rf_addr;
  logic [DW-1:0] rf_data;
  logic [PW-1:0] ptr0 = 0, ptr1 = 0;
  logic [BW-1:0] bank0 = 0, bank1 = 0;
  logic [PAW-1:0] pa = 0;
  logic io_req, io_ack = 0;
  logic [PAW-1:0] io_addr;
  logic [7:0] io_rdata = 0;
  logic mem_req, mem_ack = 0;
  logic [BW+PW-1:0] mem_addr;
  logic [7:0] mem_wdata;
  logic ptr_we, ptr_sel, done;
  logic [PW-1:0] ptr_new;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign rf_data = {8'hA0 | 8'(rf_addr), 8'h05 + 8'(rf_addr) * 8'h13};

  byte_stack_push #(.DW(DW), .PW(PW), .BW(BW), .PAW(PAW)) u0 (
    .clk, .rst_n, .cmd_valid, .cmd_reg, .cmd_sel, .cmd_dec, .busy,
    .rf_addr, .rf_data, .ptr0, .ptr1, .bank0, .bank1, .pa,
    .io_req, .io_addr, .io_ack, .io_rdata,
    .mem_req, .mem_addr, .mem_wdata, .mem_ack,
    .ptr_we, .ptr_sel, .ptr_new, .done);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] pval(input int k);
    case (k)
      0: return 8'h00;
      1: return 8'hFF;
      2: return 8'h80;
      default: return 8'h5A;
    endcase
  endfunction

  task automatic push(input bit sel, input bit dec, input int r, input int k);
    logic [PW-1:0] p, np;
    logic [BW-1:0] bk;
    logic [7:0] exp_byte, iob;
    int io_dly, mem_dly, icnt, mcnt, cyc;
    bit io_seen, io_acked, mem_done, first_mem, poked;
    p   = pval(k);
    np  = dec ? p - 1'b1 : p + 1'b1;
    bk  = sel ? BW'(~k) : BW'(k);
    iob = 8'hC0 + 8'(r * 8) + 8'(k);
    exp_byte = (r >= 4) ? iob : 8'h05 + 8'(r) * 8'h13;
    io_dly  = (r + k) % 3;
    mem_dly = (k + int'(sel) + r) % 3;
    icnt = 0; mcnt = 0; io_seen = 0; io_acked = 0; mem_done = 0; first_mem = 1; poked = 0;

    @(negedge clk);
    ptr0 = sel ? ~p : p;
    ptr1 = sel ? p : ~p;
    bank0 = sel ? ~bk : bk;
    bank1 = sel ? bk : ~bk;
    pa = PAW'(r * 3 + k + int'(sel));
    cmd_reg = 3'(r); cmd_sel = sel; cmd_dec = dec; cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
    pa = ~pa;
    cyc = 0;
    while (!mem_done && cyc < 40) begin
      if (io_req) begin
        if (!io_seen) chk(r >= 4, "R6 io_req only for sources 4..7", r, 4);
        if (!io_seen) chk(io_addr == ~pa, "R6 io_addr", io_addr, ~pa);
        io_seen = 1;
        if (icnt == io_dly) begin
          io_ack = 1; io_rdata = iob; io_acked = 1;
        end else begin
          icnt++;
          if (!poked) begin
            cmd_valid = 1; cmd_reg = ~cmd_reg; cmd_sel = ~sel; poked = 1;
          end
        end
      end
      if (mem_req) begin
        if (first_mem) begin
          chk(r < 4 || io_acked, "R7 mem_req after io_ack", io_acked, 1);
          chk(mem_addr == {bk, np}, "R2/R4/R5 mem_addr", mem_addr, {bk, np});
          if (r < 4) chk(mem_wdata == exp_byte, "R1 low byte pushed", mem_wdata, exp_byte);
          else       chk(mem_wdata == exp_byte, "R6 io byte pushed", mem_wdata, exp_byte);
          first_mem = 0;
        end else begin
          chk(mem_addr == {bk, np} && mem_wdata == exp_byte,
              "R8/R10 write held while stalled", mem_addr, {bk, np});
        end
        if (mcnt == mem_dly) begin
          mem_ack = 1; mem_done = 1;
        end else begin
          mcnt++;
          if (!poked) begin
            cmd_valid = 1; cmd_reg = ~cmd_reg; cmd_sel = ~sel; poked = 1;
          end
        end
      end
      @(negedge clk);
      io_ack = 0; mem_ack = 0; cmd_valid = 0;
      cyc++;
    end
    chk(mem_done, "R8 write accepted", mem_done, 1);
    if (r < 4) chk(!io_seen, "R6 no io for sources 0..3", io_seen, 0);
    else       chk(io_seen, "R6 io cycle for sources 4..7", io_seen, 1);
    chk(done && ptr_we, "R8 done after accept", {done, ptr_we}, 3);
    chk(ptr_sel == sel, "R3 ptr_sel", ptr_sel, sel);
    chk(ptr_new == np, dec ? "R3 R5 decrement" : "R3 R5 increment", ptr_new, np);
    @(negedge clk);
    chk(!done && !ptr_we, "R8 done one cycle", {done, ptr_we}, 0);
    @(negedge clk);
    chk(!busy && !mem_req && !io_req, "R10 no extra push started", {busy, mem_req, io_req}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !mem_req && !io_req && !done && !ptr_we, "R9 reset state",
        {busy, mem_req, io_req, done, ptr_we}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done, "R9 idle after reset", {busy, done}, 0);
    for (int s = 0; s < 2; s++)
      for (int d = 0; d < 2; d++)
        for (int r = 0; r < 8; r++)
          for (int k = 0; k < 4; k++)
            push(s[0], d[0], r, k);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule